// File: doc/BRIEF.md
# Control Endpoint Transfer Sequencer

This block steers control transfers on endpoint 0 through their setup, data and status stages. It takes three kinds of event: a setup packet has arrived, an OUT packet has been received, and an IN packet has been sent. With a setup event it also takes the received byte count and the 8-byte setup packet. Its outputs are one-cycle requests: arm reception, arm transmission of a chunk at a given offset and length (length 0 is a status reply), or stall the endpoint. It also holds the device address and reports configuration selections. All outputs are registered and appear one clock after the event that causes them.

The block handles descriptor reads, address assignment and configuration selection itself. For every other request, an external agent returns a handled flag and a stage code in the same cycle as the setup event. Descriptor lookup is external: the lookup returns a found flag and a size, and the block emits offsets and chunk lengths into that descriptor. A long reply is split into chunks of at most `MAX_PKT` bytes. A new address takes effect only after its status IN packet has gone out.

Top module: `ctrl_ep_seq`

## Requirements
- R1: After `rst_ni` the state is SETUP, every pulse output is 0 and the address register is 0 with its enable cleared. `state_o` encodes SETUP=0, DATA_TX=1, DATA_RX=2, STATUS_TX=3 and STATUS_RX=4. A `bus_reset_i` pulse forces SETUP, loads address 0 with the enable set, discards any remaining chunk bytes, and pulses `arm_rx_o` one cycle later.
- R2: A setup event whose `setup_len_i` is not 8 pulses `stall_o` and leaves the state at SETUP. The packet bytes are byte k at bits [8k+7:8k]: byte 0 is the request type, byte 1 is the request code, and bytes 2-3, 4-5 and 6-7 are the little-endian value, index and length fields.
- R3: A request with type 0x80, 0x81 or 0x82 and code 6 is a descriptor read. If `desc_found_i` is set, the block arms TX at offset 0 with min(total, `MAX_PKT`) bytes and enters DATA_TX, where total is min(length field, `desc_size_i`). If `desc_found_i` is clear, it stalls and stays in SETUP.
- R4: While bytes of the reply remain, each `tx_done_i` in DATA_TX arms TX with min(remaining, `MAX_PKT`) bytes, at an offset equal to the bytes already sent.
- R5: A `tx_done_i` in DATA_TX with no bytes remaining moves the state to STATUS_RX and arms RX. In STATUS_RX, `rx_done_i` with `rx_len_i`=0 arms RX; with any other length it stalls. Either way the state returns to SETUP.
- R6: A request with type 0x00 and code 5 arms a zero-length TX and enters STATUS_TX. The address outputs stay unchanged until `tx_done_i` in STATUS_TX. At that point they take the low `ADDR_W` bits of the value field with the enable set, RX is armed and the state returns to SETUP.
- R7: A request with type 0x00 and code 9 pulses `cfg_valid_o` with `cfg_idx_o` equal to the value field, arms a zero-length TX and enters STATUS_TX. The following `tx_done_i` arms RX and returns to SETUP.
- R8: Any other request with `ext_handled_i`=0 stalls and stays in SETUP. When it is handled, `ext_stage_i` decides the next step:
  - 0: zero-length TX and STATUS_TX.
  - 1: chunked reply of the length field and DATA_TX.
  - 2: arm RX and DATA_RX. The next `rx_done_i` then arms a zero-length TX and enters STATUS_TX.
  - 3: stall and stay in SETUP.
- R9: A setup event in any state abandons the stage in progress. Remaining chunk bytes and a pending address are dropped, and the new request is handled as if from SETUP.
- R10: Events that do not belong to the current state cause no output pulse and no state change. Examples are `tx_done_i` in SETUP, STATUS_RX or DATA_RX, and `rx_done_i` in SETUP, DATA_TX or STATUS_TX. At most one of `arm_tx_o`, `arm_rx_o` and `stall_o` is high in any cycle.
- R11: `bus_reset_i` takes priority over a setup event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | Bus reset seen on the link |
| setup_valid_i | input | 1 | Setup packet received |
| setup_len_i | input | 4 | Byte count of the setup packet |
| setup_data_i | input | 64 | Setup packet bytes, byte 0 in the low bits |
| desc_found_i | input | 1 | External lookup found the requested descriptor |
| desc_size_i | input | 16 | Size of the found descriptor |
| ext_handled_i | input | 1 | External agent accepts a non-standard request |
| ext_stage_i | input | 2 | Next stage chosen by the external agent |
| rx_done_i | input | 1 | OUT packet received |
| rx_len_i | input | RXLEN_W | Byte count of the OUT packet |
| tx_done_i | input | 1 | IN packet sent |
| arm_rx_o | output | 1 | Request to accept the next OUT packet |
| arm_tx_o | output | 1 | Request to send a chunk |
| tx_len_o | output | CHUNK_W | Chunk length, 0 for a status reply |
| tx_off_o | output | 16 | Chunk offset into the reply |
| stall_o | output | 1 | Request to stall the endpoint |
| cfg_valid_o | output | 1 | Configuration selected |
| cfg_idx_o | output | 16 | Selected configuration index |
| dev_addr_o | output | ADDR_W | Device address |
| addr_en_o | output | 1 | Device address enable |
| state_o | output | 3 | Current stage |

## Verification
Descriptor reads are swept over every allowed request type, with reply lengths chosen around multiples of 64. The sweep includes empty, exactly-full and one-over chunks, and both the length field and the descriptor size act as the limiting value, which separates off-by-one faults in chunk length, offset and the termination test. Status OUT packets alternate between zero and non-zero length to confirm the stall decision. Address, configuration and externally handled requests run through all four stage codes. New setups and bus resets are injected during data and status stages to show that pending chunks and pending addresses are discarded. Events that do not match the current state are checked for having no effect.

// File: rtl/ctrl_ep_pkg.sv
package ctrl_ep_pkg;
  typedef enum logic [2:0] {
    ST_SETUP     = 3'd0,
    ST_DATA_TX   = 3'd1,
    ST_DATA_RX   = 3'd2,
    ST_STATUS_TX = 3'd3,
    ST_STATUS_RX = 3'd4
  } ep0_state_e;

  typedef enum logic [2:0] {
    RQ_BAD_LEN,
    RQ_GET_DESC,
    RQ_SET_ADDR,
    RQ_SET_CFG,
    RQ_OTHER
  } req_kind_e;

  localparam int unsigned SETUP_BYTES = 8;
  localparam int unsigned FIELD_W     = 16;
endpackage

// File: rtl/ctrl_req_decode.sv
module ctrl_req_decode
  import ctrl_ep_pkg::*;
(
  input  logic [3:0] len_i,
  input  logic [7:0] req_type_i,
  input  logic [7:0] req_code_i,
  output req_kind_e  kind_o
);
  logic dev_to_host_std;

  // standard device/interface/endpoint IN requests
  assign dev_to_host_std = (req_type_i == 8'h80) || (req_type_i == 8'h81) ||
                           (req_type_i == 8'h82);

  always_comb begin
    if (len_i != 4'(SETUP_BYTES))                        kind_o = RQ_BAD_LEN;
    else if (dev_to_host_std && req_code_i == 8'd6)      kind_o = RQ_GET_DESC;
    else if (req_type_i == 8'h00 && req_code_i == 8'd5)  kind_o = RQ_SET_ADDR;
    else if (req_type_i == 8'h00 && req_code_i == 8'd9)  kind_o = RQ_SET_CFG;
    else                                                 kind_o = RQ_OTHER;
  end
endmodule

// File: rtl/ctrl_chunk_ctr.sv
module ctrl_chunk_ctr #(
  parameter int unsigned MAX_PKT = 64,
  parameter int unsigned LEN_W   = 16,
  localparam int unsigned CHUNK_W = $clog2(MAX_PKT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               load_i,
  input  logic [LEN_W-1:0]   total_i,
  input  logic               step_i,
  output logic [CHUNK_W-1:0] ld_chunk_o,
  output logic [CHUNK_W-1:0] nx_chunk_o,
  output logic [LEN_W-1:0]   off_o,
  output logic               pending_o
);
  localparam logic [LEN_W-1:0]   MAX_L = LEN_W'(MAX_PKT);
  localparam logic [CHUNK_W-1:0] MAX_C = CHUNK_W'(MAX_PKT);

  logic [LEN_W-1:0] rem_q, off_q;

  assign ld_chunk_o = (total_i > MAX_L) ? MAX_C : total_i[CHUNK_W-1:0];
  assign nx_chunk_o = (rem_q > MAX_L) ? MAX_C : rem_q[CHUNK_W-1:0];
  assign off_o      = off_q;
  assign pending_o  = (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      off_q <= '0;
    end else if (load_i) begin
      rem_q <= total_i - LEN_W'(ld_chunk_o);
      off_q <= LEN_W'(ld_chunk_o);
    end else if (clear_i) begin
      rem_q <= '0;
      off_q <= '0;
    end else if (step_i) begin
      rem_q <= rem_q - LEN_W'(nx_chunk_o);
      off_q <= off_q + LEN_W'(nx_chunk_o);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !clear_i |-> rem_q != '0);  // R4
endmodule

// File: rtl/ctrl_ep_seq.sv
module ctrl_ep_seq
  import ctrl_ep_pkg::*;
#(
  parameter int unsigned MAX_PKT = 64,
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned RXLEN_W = 7,
  localparam int unsigned CHUNK_W = $clog2(MAX_PKT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_reset_i,
  input  logic               setup_valid_i,
  input  logic [3:0]         setup_len_i,
  input  logic [63:0]        setup_data_i,
  input  logic               desc_found_i,
  input  logic [15:0]        desc_size_i,
  input  logic               ext_handled_i,
  input  logic [1:0]         ext_stage_i,
  input  logic               rx_done_i,
  input  logic [RXLEN_W-1:0] rx_len_i,
  input  logic               tx_done_i,
  output logic               arm_rx_o,
  output logic               arm_tx_o,
  output logic [CHUNK_W-1:0] tx_len_o,
  output logic [15:0]        tx_off_o,
  output logic               stall_o,
  output logic               cfg_valid_o,
  output logic [15:0]        cfg_idx_o,
  output logic [ADDR_W-1:0]  dev_addr_o,
  output logic               addr_en_o,
  output logic [2:0]         state_o
);
  localparam int unsigned LEN_W = FIELD_W;

  logic [7:0]       req_type, req_code;
  logic [LEN_W-1:0] w_value, w_length, desc_tot;
  logic             unused_idx;

  assign req_type   = setup_data_i[7:0];
  assign req_code   = setup_data_i[15:8];
  assign w_value    = setup_data_i[31:16];
  assign w_length   = setup_data_i[63:48];
  assign unused_idx = ^setup_data_i[47:32];
  assign desc_tot   = (w_length < desc_size_i) ? w_length : desc_size_i;

  req_kind_e kind;

  ctrl_req_decode u_dec (
    .len_i      (setup_len_i),
    .req_type_i (req_type),
    .req_code_i (req_code),
    .kind_o     (kind)
  );

  logic               ck_clear, ck_load, ck_step, ck_pending;
  logic [LEN_W-1:0]   ck_total, ck_off;
  logic [CHUNK_W-1:0] ck_ld_chunk, ck_nx_chunk;

  ctrl_chunk_ctr #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) u_chunk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (ck_clear),
    .load_i     (ck_load),
    .total_i    (ck_total),
    .step_i     (ck_step),
    .ld_chunk_o (ck_ld_chunk),
    .nx_chunk_o (ck_nx_chunk),
    .off_o      (ck_off),
    .pending_o  (ck_pending)
  );

  ep0_state_e         state_q, state_d;
  logic               arm_rx_q, arm_rx_d, arm_tx_q, arm_tx_d, stall_q, stall_d;
  logic               cfg_v_q, cfg_v_d;
  logic [15:0]        cfg_idx_q, cfg_idx_d;
  logic [CHUNK_W-1:0] tx_len_q, tx_len_d;
  logic [LEN_W-1:0]   tx_off_q, tx_off_d;
  logic [ADDR_W-1:0]  addr_q, addr_d, pend_q, pend_d;
  logic               addr_en_q, addr_en_d, pend_v_q, pend_v_d;

  always_comb begin
    state_d   = state_q;
    arm_rx_d  = 1'b0;
    arm_tx_d  = 1'b0;
    stall_d   = 1'b0;
    cfg_v_d   = 1'b0;
    cfg_idx_d = cfg_idx_q;
    tx_len_d  = '0;
    tx_off_d  = '0;
    addr_d    = addr_q;
    addr_en_d = addr_en_q;
    pend_d    = pend_q;
    pend_v_d  = pend_v_q;
    ck_clear  = 1'b0;
    ck_load   = 1'b0;
    ck_step   = 1'b0;
    ck_total  = desc_tot;

    if (bus_reset_i) begin
      state_d   = ST_SETUP;
      addr_d    = '0;
      addr_en_d = 1'b1;
      pend_v_d  = 1'b0;
      ck_clear  = 1'b1;
      arm_rx_d  = 1'b1;
    end else if (setup_valid_i) begin
      // a new setup abandons whatever stage was running
      state_d  = ST_SETUP;
      pend_v_d = 1'b0;
      ck_clear = 1'b1;
      unique case (kind)
        RQ_BAD_LEN: stall_d = 1'b1;
        RQ_GET_DESC: begin
          if (desc_found_i) begin
            ck_load  = 1'b1;
            arm_tx_d = 1'b1;
            tx_len_d = ck_ld_chunk;
            state_d  = ST_DATA_TX;
          end else begin
            stall_d = 1'b1;
          end
        end
        RQ_SET_ADDR: begin
          arm_tx_d = 1'b1;
          state_d  = ST_STATUS_TX;
          pend_d   = w_value[ADDR_W-1:0];
          pend_v_d = 1'b1;
        end
        RQ_SET_CFG: begin
          cfg_v_d   = 1'b1;
          cfg_idx_d = w_value;
          arm_tx_d  = 1'b1;
          state_d   = ST_STATUS_TX;
        end
        default: begin
          if (!ext_handled_i) begin
            stall_d = 1'b1;
          end else begin
            unique case (ext_stage_i)
              2'd0: begin
                arm_tx_d = 1'b1;
                state_d  = ST_STATUS_TX;
              end
              2'd1: begin
                ck_total = w_length;
                ck_load  = 1'b1;
                arm_tx_d = 1'b1;
                tx_len_d = ck_ld_chunk;
                state_d  = ST_DATA_TX;
              end
              2'd2: begin
                arm_rx_d = 1'b1;
                state_d  = ST_DATA_RX;
              end
              default: stall_d = 1'b1;
            endcase
          end
        end
      endcase
    end else begin
      unique case (state_q)
        ST_DATA_TX: if (tx_done_i) begin
          if (ck_pending) begin
            ck_step  = 1'b1;
            arm_tx_d = 1'b1;
            tx_len_d = ck_nx_chunk;
            tx_off_d = ck_off;
          end else begin
            arm_rx_d = 1'b1;
            state_d  = ST_STATUS_RX;
          end
        end
        ST_DATA_RX: if (rx_done_i) begin
          arm_tx_d = 1'b1;
          state_d  = ST_STATUS_TX;
        end
        ST_STATUS_TX: if (tx_done_i) begin
          if (pend_v_q) begin
            addr_d    = pend_q;
            addr_en_d = 1'b1;
            pend_v_d  = 1'b0;
          end
          arm_rx_d = 1'b1;
          state_d  = ST_SETUP;
        end
        ST_STATUS_RX: if (rx_done_i) begin
          if (rx_len_i != '0) stall_d  = 1'b1;
          else                arm_rx_d = 1'b1;
          state_d = ST_SETUP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SETUP;
      arm_rx_q  <= 1'b0;
      arm_tx_q  <= 1'b0;
      stall_q   <= 1'b0;
      cfg_v_q   <= 1'b0;
      cfg_idx_q <= '0;
      tx_len_q  <= '0;
      tx_off_q  <= '0;
      addr_q    <= '0;
      addr_en_q <= 1'b0;
      pend_q    <= '0;
      pend_v_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      arm_rx_q  <= arm_rx_d;
      arm_tx_q  <= arm_tx_d;
      stall_q   <= stall_d;
      cfg_v_q   <= cfg_v_d;
      cfg_idx_q <= cfg_idx_d;
      tx_len_q  <= tx_len_d;
      tx_off_q  <= tx_off_d;
      addr_q    <= addr_d;
      addr_en_q <= addr_en_d;
      pend_q    <= pend_d;
      pend_v_q  <= pend_v_d;
    end
  end

  assign arm_rx_o    = arm_rx_q;
  assign arm_tx_o    = arm_tx_q;
  assign stall_o     = stall_q;
  assign tx_len_o    = tx_len_q;
  assign tx_off_o    = tx_off_q;
  assign cfg_valid_o = cfg_v_q;
  assign cfg_idx_o   = cfg_idx_q;
  assign dev_addr_o  = addr_q;
  assign addr_en_o   = addr_en_q;
  assign state_o     = state_q;

  AST_BUS_RESET_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> state_o == ST_SETUP && addr_en_o && dev_addr_o == '0 && arm_rx_o);  // R1
  AST_STALL_IN_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> state_o == ST_SETUP);  // R2
  AST_CHUNK_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_tx_o |-> tx_len_o <= CHUNK_W'(MAX_PKT));  // R4
  AST_ADDR_AFTER_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({addr_en_o, dev_addr_o}) |->
      $past(bus_reset_i) || ($past(state_o == ST_STATUS_TX) && $past(tx_done_i)));  // R6
  AST_SINGLE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({arm_tx_o, arm_rx_o, stall_o}));  // R10
endmodule

// File: tb/sim_ctrl_ep_seq.sv
module sim_ctrl_ep_seq;
  localparam int MAXP = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_reset_i = 1'b0, setup_valid_i = 1'b0;
  logic [3:0]  setup_len_i = '0;
  logic [63:0] setup_data_i = '0;
  logic        desc_found_i = 1'b0;
  logic [15:0] desc_size_i = '0;
  logic        ext_handled_i = 1'b0;
  logic [1:0]  ext_stage_i = '0;
  logic        rx_done_i = 1'b0, tx_done_i = 1'b0;
  logic [6:0]  rx_len_i = '0;
  logic        arm_rx_o, arm_tx_o, stall_o, cfg_valid_o, addr_en_o;
  logic [6:0]  tx_len_o, dev_addr_o;
  logic [15:0] tx_off_o, cfg_idx_o;
  logic [2:0]  state_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctrl_ep_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i),
    .setup_valid_i(setup_valid_i), .setup_len_i(setup_len_i), .setup_data_i(setup_data_i),
    .desc_found_i(desc_found_i), .desc_size_i(desc_size_i),
    .ext_handled_i(ext_handled_i), .ext_stage_i(ext_stage_i),
    .rx_done_i(rx_done_i), .rx_len_i(rx_len_i), .tx_done_i(tx_done_i),
    .arm_rx_o(arm_rx_o), .arm_tx_o(arm_tx_o), .tx_len_o(tx_len_o), .tx_off_o(tx_off_o),
    .stall_o(stall_o), .cfg_valid_o(cfg_valid_o), .cfg_idx_o(cfg_idx_o),
    .dev_addr_o(dev_addr_o), .addr_en_o(addr_en_o), .state_o(state_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_out(string tag, bit etx, int elen, int eoff, bit erx, bit est, int est8);
    logic [28:0] act, exp;
    act = {arm_tx_o, arm_rx_o, stall_o, state_o, tx_len_o, tx_off_o};
    exp = {etx, erx, est, 3'(est8), 7'(elen), 16'(eoff)};
    chk(tag, 32'(act), 32'(exp));
  endtask

  task automatic finish_ev();
    @(negedge clk);
    bus_reset_i = 0; setup_valid_i = 0; rx_done_i = 0; tx_done_i = 0;
  endtask

  task automatic ev_setup(int typ, int code, int val, int wlen, int len = 8,
                          bit found = 0, int size = 0, bit hnd = 0, int stg = 0);
    setup_valid_i = 1; setup_len_i = 4'(len);
    setup_data_i = {16'(wlen), 16'h0000, 16'(val), 8'(code), 8'(typ)};
    desc_found_i = found; desc_size_i = 16'(size);
    ext_handled_i = hnd; ext_stage_i = 2'(stg);
    finish_ev();
  endtask

  task automatic ev_tx();  tx_done_i = 1; finish_ev(); endtask
  task automatic ev_rx(int n); rx_done_i = 1; rx_len_i = 7'(n); finish_ev(); endtask
  task automatic ev_bus(); bus_reset_i = 1; finish_ev(); endtask

  // walk a chunked IN data stage of 'total' bytes, whose first arm has just occurred
  task automatic walk_data(string tag, int total);
    int sent, c;
    c = (total > MAXP) ? MAXP : total;
    expect_out({tag, " R3 first chunk"}, 1, c, 0, 0, 0, 1);
    sent = c;
    while (sent < total) begin
      ev_tx();
      c = (total - sent > MAXP) ? MAXP : total - sent;
      expect_out({tag, " R4 next chunk"}, 1, c, sent, 0, 0, 1);
      sent += c;
    end
    ev_tx();
    expect_out({tag, " R5 to status rx"}, 0, 0, 0, 1, 0, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int wl [6] = '{0, 1, 64, 65, 128, 300};
    int sz [4] = '{1, 63, 129, 200};
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    expect_out("R1 reset", 0, 0, 0, 0, 0, 0);
    chk("R1 reset addr", {24'd0, addr_en_o, dev_addr_o}, 32'd0);
    chk("R1 reset cfg", {15'd0, cfg_valid_o, cfg_idx_o}, 32'd0);
    ev_bus();
    expect_out("R1 bus reset", 0, 0, 0, 1, 0, 0);
    chk("R1 bus reset addr", {24'd0, addr_en_o, dev_addr_o}, 32'h80);
    // R10 stray events in SETUP
    ev_tx(); expect_out("R10 tx in setup", 0, 0, 0, 0, 0, 0);
    ev_rx(0); expect_out("R10 rx in setup", 0, 0, 0, 0, 0, 0);

    // R3/R4/R5 descriptor sweep
    n = 0;
    for (int t = 8'h80; t <= 8'h82; t++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 4; j++) begin
          int tot;
          tot = (wl[i] < sz[j]) ? wl[i] : sz[j];
          ev_setup(t, 6, 16'h0100, wl[i], 8, 1, sz[j]);
          walk_data("desc", tot);
          if (n % 3 == 2) begin
            ev_rx(n % 64 + 1); expect_out("R5 nonzero status stall", 0, 0, 0, 0, 1, 0);
          end else begin
            ev_rx(0); expect_out("R5 zero status", 0, 0, 0, 1, 0, 0);
          end
          n++;
        end
    ev_setup(8'h80, 6, 0, 18, 8, 0, 18);
    expect_out("R3 not found stall", 0, 0, 0, 0, 1, 0);
    ev_setup(8'h83, 6, 0, 18, 8, 1, 18, 0);
    expect_out("R8 type 0x83 not handled", 0, 0, 0, 0, 1, 0);
    // R2 short setups
    for (int l = 0; l < 16; l++) if (l != 8) begin
      ev_setup(8'h80, 6, 0, 18, l, 1, 18);
      expect_out("R2 bad length stall", 0, 0, 0, 0, 1, 0);
    end

    // R6 set address
    ev_setup(8'h00, 5, 16'h002A, 0);
    expect_out("R6 status tx armed", 1, 0, 0, 0, 0, 3);
    chk("R6 addr held", {24'd0, addr_en_o, dev_addr_o}, 32'h80);
    ev_rx(0); expect_out("R10 rx in status tx", 0, 0, 0, 0, 0, 3);
    chk("R6 addr still held", {24'd0, addr_en_o, dev_addr_o}, 32'h80);
    ev_tx(); expect_out("R6 status done", 0, 0, 0, 1, 0, 0);
    chk("R6 addr loaded", {24'd0, addr_en_o, dev_addr_o}, 32'hAA);

    // R7 set configuration
    ev_setup(8'h00, 9, 16'h0003, 0);
    expect_out("R7 status tx armed", 1, 0, 0, 0, 0, 3);
    chk("R7 cfg pulse", {15'd0, cfg_valid_o, cfg_idx_o}, 32'h10003);
    ev_tx(); expect_out("R7 status done", 0, 0, 0, 1, 0, 0);
    chk("R7 cfg pulse ends", {31'd0, cfg_valid_o}, 32'd0);

    // R9 abort mid data stage
    ev_setup(8'h80, 6, 0, 200, 8, 1, 200);
    ev_tx(); expect_out("R4 second chunk", 1, 64, 64, 0, 0, 1);
    ev_setup(8'h00, 9, 16'h0005, 0);
    expect_out("R9 abort to status", 1, 0, 0, 0, 0, 3);
    ev_tx(); expect_out("R9 no leftover chunk", 0, 0, 0, 1, 0, 0);
    // R9 abort pending address
    ev_setup(8'h00, 5, 16'h0011, 0);
    ev_setup(8'h00, 9, 16'h0001, 0);
    ev_tx(); expect_out("R9 status after abort", 0, 0, 0, 1, 0, 0);
    chk("R9 pending addr dropped", {24'd0, addr_en_o, dev_addr_o}, 32'hAA);

    // R8 external requests
    ev_setup(8'h21, 9, 0, 0, 8, 0, 0, 0);
    expect_out("R8 not handled", 0, 0, 0, 0, 1, 0);
    ev_setup(8'h21, 9, 0, 0, 8, 0, 0, 1, 0);
    expect_out("R8 stage status", 1, 0, 0, 0, 0, 3);
    ev_tx(); expect_out("R8 status done", 0, 0, 0, 1, 0, 0);
    ev_setup(8'hA1, 1, 0, 130, 8, 0, 0, 1, 1);
    walk_data("ext", 130);
    ev_rx(0); expect_out("R8 ext status", 0, 0, 0, 1, 0, 0);
    ev_setup(8'h21, 1, 0, 7, 8, 0, 0, 1, 2);
    expect_out("R8 stage data rx", 0, 0, 0, 1, 0, 2);
    ev_tx(); expect_out("R10 tx in data rx", 0, 0, 0, 0, 0, 2);
    ev_rx(7); expect_out("R8 data rx done", 1, 0, 0, 0, 0, 3);
    ev_tx(); expect_out("R8 final", 0, 0, 0, 1, 0, 0);
    ev_setup(8'h21, 1, 0, 7, 8, 0, 0, 1, 3);
    expect_out("R8 stage stall", 0, 0, 0, 0, 1, 0);

    // R11 bus reset beats setup, R1 clears pending chunk
    ev_setup(8'h80, 6, 0, 200, 8, 1, 200);
    setup_valid_i = 1; setup_len_i = 8; setup_data_i = {16'd0, 16'd0, 16'h0009, 8'd5, 8'h00};
    bus_reset_i = 1; finish_ev();
    expect_out("R11 bus reset priority", 0, 0, 0, 1, 0, 0);
    chk("R1 addr cleared", {24'd0, addr_en_o, dev_addr_o}, 32'h80);
    ev_tx(); expect_out("R1 chunks dropped", 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule